// File: doc/BRIEF.md
# Bus-Activity Watchdog Reset Generator

This block supervises a serial bus by watching its active-low chip-select line. Each new transaction on the bus restarts an internal timer. If no transaction starts before the selected time-out expires, the block emits a reset pulse of fixed length. The pulse comes out in both polarities, so either kind of reset consumer can use it. When the pulse ends, the timer starts again from zero.

A 2-bit code selects the time-out. This code normally comes from bits that the memory controller holds in its status register. Three codes pick periods of 14, 6 or 2 ticks, which keeps the ratio between the long, medium and short periods. The fourth code turns the watchdog off. A tick is `TICK_CLKS` system clocks long, so a bench can use short periods and a chip can scale the tick up to real time. Power-on reset also produces one full reset pulse.

Top module: `bus_wdt_reset`

## Requirements
- R1: While `por_n` is low, `rst_hi` is 1. After `por_n` rises, `rst_hi` stays 1 through the first `PULSE_CLKS`-1 clock edges and is 0 after edge `PULSE_CLKS`.
- R2: Select codes `tmo_sel` = 2'b00, 2'b01 and 2'b10 give time-outs of 14, 6 and 2 ticks. A tick is `TICK_CLKS` clocks. Take the clock edge at which the timer restarts as edge 0. Then `rst_hi` rises right after edge limit*`TICK_CLKS`, and it is 0 at the edge before that.
- R3: With `tmo_sel` = 2'b11, no time-out fires, however long the bus stays idle.
- R4: A time-out pulse holds `rst_hi` at 1 for exactly `PULSE_CLKS` clocks. The timer restarts from zero at the edge where the pulse ends.
- R5: A falling edge on `bus_cs_n` counts as activity. The line first passes through a 2-stage synchronizer. The timer restarts at the third clock edge after the line falls. A line held low does not count as activity.
- R6: A change of `tmo_sel` restarts the timer at the first edge that sees the new code. A shorter period therefore cannot fire at once.
- R7: `rst_lo_n` is always the complement of `rst_hi`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| bus_cs_n | input | 1 | Serial bus chip-select, active low, asynchronous to `clk` |
| tmo_sel | input | 2 | Time-out select code (00 long, 01 medium, 10 short, 11 off) |
| rst_hi | output | 1 | Reset pulse, active high |
| rst_lo_n | output | 1 | Reset pulse, active low |

## Verification
The assertions check several properties on every cycle:
- the two outputs are complementary;
- a pulse rises only when the tick count has reached the limit for the current code;
- the pulse counter never goes above its length;
- the disable code keeps a quiet output quiet;
- detected activity or a code change leaves the timer at zero.

Some behaviour shows only in the bench's scenarios, because it needs exact cycle counts over long idle stretches:
- the time-out lengths for each code;
- the pulse length, and the restart from zero when the pulse ends;
- the power-on pulse;
- the synchronizer latency;
- the fact that a chip-select held low is not activity.

// File: rtl/bus_wdt_reset.sv
module bus_wdt_reset #(
  parameter int TICK_CLKS   = 4,
  parameter int PULSE_CLKS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       bus_cs_n,
  input  logic [1:0] tmo_sel,
  output logic       rst_hi,
  output logic       rst_lo_n
);

  localparam int PW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
  localparam int CW = $clog2(PULSE_CLKS + 1);
  localparam int TW = 4;

  logic [SYNC_STAGES-1:0] cs_sync;
  logic                   cs_prev;
  logic [1:0]             sel_q;
  logic [PW-1:0]          presc;
  logic [TW-1:0]          tick_cnt;
  logic [CW-1:0]          pulse_cnt;
  logic [TW-1:0]          limit;

  logic activity, sel_chg, disabled, pulse_on, restart, tick, timeout;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      cs_sync <= '1;
      cs_prev <= 1'b1;
      sel_q   <= 2'b11;
    end else begin
      cs_sync <= {cs_sync[SYNC_STAGES-2:0], bus_cs_n};
      cs_prev <= cs_sync[SYNC_STAGES-1];
      sel_q   <= tmo_sel;
    end

  always_comb
    case (sel_q)
      2'b00:   limit = TW'(14);
      2'b01:   limit = TW'(6);
      2'b10:   limit = TW'(2);
      default: limit = TW'(0);
    endcase

  assign activity = cs_prev & ~cs_sync[SYNC_STAGES-1];
  assign sel_chg  = tmo_sel != sel_q;
  assign disabled = sel_q == 2'b11;
  assign pulse_on = pulse_cnt != '0;
  assign restart  = activity | sel_chg | disabled | pulse_on;
  assign tick     = presc == PW'(TICK_CLKS - 1);
  assign timeout  = !restart && tick && (tick_cnt == limit - TW'(1));

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      presc    <= '0;
      tick_cnt <= '0;
    end else if (restart || timeout) begin
      presc    <= '0;
      tick_cnt <= '0;
    end else begin
      presc <= tick ? '0 : presc + PW'(1);
      if (tick) tick_cnt <= tick_cnt + TW'(1);
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)        pulse_cnt <= CW'(PULSE_CLKS);
    else if (timeout)  pulse_cnt <= CW'(PULSE_CLKS);
    else if (pulse_on) pulse_cnt <= pulse_cnt - CW'(1);

  assign rst_hi   = pulse_on;
  assign rst_lo_n = ~pulse_on;

endmodule

module bus_wdt_reset_chk #(
  parameter int PULSE_CLKS = 3
) (
  input logic       clk,
  input logic       por_n,
  input logic       rst_hi,
  input logic       rst_lo_n,
  input logic [1:0] tmo_sel,
  input logic [1:0] sel_q,
  input logic       activity,
  input logic       sel_chg,
  input logic [3:0] tick_cnt,
  input logic [3:0] limit,
  input logic [$clog2(PULSE_CLKS+1)-1:0] pulse_cnt
);

  assert_complement_R7: assert property (@(posedge clk) disable iff (!por_n)
    rst_lo_n != rst_hi);

  assert_rise_at_limit_R2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_hi) |-> ($past(tick_cnt) == $past(limit) - 4'd1 && $past(limit) != 4'd0));

  assert_pulse_bound_R4: assert property (@(posedge clk) disable iff (!por_n)
    pulse_cnt <= PULSE_CLKS);

  assert_disable_quiet_R3: assert property (@(posedge clk) disable iff (!por_n)
    (sel_q == 2'b11 && tmo_sel == 2'b11 && !rst_hi) |=> !rst_hi);

  assert_activity_clears_R5: assert property (@(posedge clk) disable iff (!por_n)
    activity |=> tick_cnt == 4'd0);

  assert_selchg_clears_R6: assert property (@(posedge clk) disable iff (!por_n)
    sel_chg |=> (tick_cnt == 4'd0 && !$rose(rst_hi)));

endmodule

bind bus_wdt_reset bus_wdt_reset_chk #(.PULSE_CLKS(PULSE_CLKS)) u_chk (
  .clk(clk), .por_n(por_n), .rst_hi(rst_hi), .rst_lo_n(rst_lo_n),
  .tmo_sel(tmo_sel), .sel_q(sel_q), .activity(activity), .sel_chg(sel_chg),
  .tick_cnt(tick_cnt), .limit(limit), .pulse_cnt(pulse_cnt)
);

// File: tb/tb_bus_wdt_reset.sv
module tb_bus_wdt_reset;
  localparam int CLK_PERIOD = 10;
  localparam int T = 4;
  localparam int P = 3;

  logic clk = 0, por_n = 0, bus_cs_n = 1;
  logic [1:0] tmo_sel = 2'b11;
  logic rst_hi, rst_lo_n;
  int checks = 0, errors = 0;

  bus_wdt_reset #(.TICK_CLKS(T), .PULSE_CLKS(P)) dut (
    .clk(clk), .por_n(por_n), .bus_cs_n(bus_cs_n), .tmo_sel(tmo_sel),
    .rst_hi(rst_hi), .rst_lo_n(rst_lo_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  // each entry: {select code, limit in ticks}
  localparam logic [5:0] VEC [0:4] = '{
    {2'b10, 4'd2}, {2'b01, 4'd6}, {2'b00, 4'd14}, {2'b10, 4'd2}, {2'b01, 4'd6}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_out(input string req, input bit exp);
    chk(rst_hi == exp, req, rst_hi, exp);
    chk(rst_lo_n == !exp, "R7", rst_lo_n, !exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int high_seen;
    // R1: power-on pulse
    #(CLK_PERIOD*2 + 2);
    chk_out("R1", 1'b1);
    @(negedge clk); por_n = 1;
    for (int k = 1; k <= P; k++) begin
      @(posedge clk); #1;
      if (k == P - 1) chk_out("R1", 1'b1);
      if (k == P)     chk_out("R1", 1'b0);
    end

    // R2/R4: time-out per code, pulse length
    for (int v = 0; v < 5; v++) begin
      int lim;
      lim = int'(VEC[v][3:0]);
      @(negedge clk); tmo_sel = VEC[v][5:4];
      @(posedge clk);
      for (int k = 1; k <= lim*T + P; k++) begin
        @(posedge clk); #1;
        if (k == 1)           chk_out("R6", 1'b0);
        if (k == lim*T - 1)   chk_out("R2", 1'b0);
        if (k == lim*T)       chk_out("R2", 1'b1);
        if (k == lim*T + P-1) chk_out("R4", 1'b1);
        if (k == lim*T + P)   chk_out("R4", 1'b0);
      end
    end

    // R4: restart from zero after pulse, second period same length
    for (int k = 1; k <= 6*T; k++) begin
      @(posedge clk); #1;
      if (k == 6*T - 1) chk_out("R4", 1'b0);
      if (k == 6*T)     chk_out("R4", 1'b1);
    end
    repeat (P) @(posedge clk);
    #1 chk_out("R4", 1'b0);

    // R3: disabled code never fires
    @(negedge clk); tmo_sel = 2'b11;
    high_seen = 0;
    repeat (20*T) begin @(posedge clk); #1; if (rst_hi) high_seen++; end
    chk(high_seen == 0, "R3", high_seen, 0);
    chk_out("R3", 1'b0);

    // R6: shorter period chosen mid-count does not fire early
    @(negedge clk); tmo_sel = 2'b00;
    repeat (40) @(negedge clk);
    tmo_sel = 2'b10;
    @(posedge clk);
    for (int k = 1; k <= 2*T + P; k++) begin
      @(posedge clk); #1;
      if (k == 1)       chk_out("R6", 1'b0);
      if (k == 2*T - 1) chk_out("R6", 1'b0);
      if (k == 2*T)     chk_out("R6", 1'b1);
    end

    // R5: regular chip-select strobes keep the output quiet
    high_seen = 0;
    for (int n = 0; n < 12; n++) begin
      @(negedge clk); bus_cs_n = 0;
      @(negedge clk); bus_cs_n = 1;
      repeat (3) begin @(negedge clk); if (rst_hi) high_seen++; end
    end
    chk(high_seen == 0, "R5", high_seen, 0);

    // R5: latency of restart and held-low line is not activity
    @(negedge clk); bus_cs_n = 0;
    repeat (3) @(posedge clk);
    for (int k = 1; k <= 2*T; k++) begin
      @(posedge clk); #1;
      if (k == 2*T - 1) chk_out("R5", 1'b0);
      if (k == 2*T)     chk_out("R5", 1'b1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule